// File: doc/BRIEF.md
# Pulse-Distance Infrared Tag Frame Generator

This block turns a 16-bit payload and an 8-bit check byte into the sample-by-sample line waveform of one 24-bit infrared tag frame. The line carries a long header mark, then a short header gap, then 24 data bits. In each data bit a space comes first and a fixed-length mark follows. The length of the space carries the bit value. The check byte is computed outside the block and is sent unchanged as the third byte of the frame.

The waveform moves forward only on clock cycles where the tick enable is high, so the sample rate can be set apart from the system clock. A start strobe latches the payload and the check byte and begins a frame. While a frame runs, busy is high. When the line goes back to idle, done pulses for one cycle. A polarity input selects which line level counts as active.

Top module: `irtag_frame_gen`

## Requirements
- R1: After reset, busy and done are low and the line sits at its inactive level. The inactive level is the value of `invert_i`.
- R2: When `start_i` is high in a cycle where busy is low, the block latches `payload_i` and `check_i`. In the next cycle, busy is high and the line is at its active level.
- R3: The frame opens with an active header mark of 32 ticks, followed by an inactive header gap of 8 ticks.
- R4: Exactly 24 data bits follow the header. Frame bit i is `payload_i[i]` for i = 0 to 15, then `check_i[i-16]` for i = 16 to 23, so each byte goes out least significant bit first.
- R5: A 1 bit is 16 inactive ticks followed by 8 active ticks.
- R6: A 0 bit is 8 inactive ticks followed by 8 active ticks.
- R7: The waveform advances only on cycles where `tick_en_i` is high. On any other cycle, the line level and busy hold their values.
- R8: A start strobe that arrives while busy is high has no effect. The frame in progress continues unchanged, using the data latched at its own start.
- R9: At the end of the last bit's mark, busy falls and the line goes back to inactive. In that same cycle done is high for exactly one cycle. The whole frame lasts 40 + 16·(zero bits) + 24·(one bits) ticks, which is at most 616.
- R10: The line level is the active flag XOR `invert_i`. With `invert_i` = 1, the active level is 0 and the idle level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Sample tick; advances the waveform by one sample |
| start_i | input | 1 | Start strobe; accepted only when idle |
| payload_i | input | 16 | Frame bytes 0 and 1; bit 0 is sent first |
| check_i | input | 8 | Frame byte 2, the externally computed check byte |
| invert_i | input | 1 | Output polarity select |
| line_o | output | 1 | Sample-rate line level |
| busy_o | output | 1 | High while a frame is being generated |
| done_o | output | 1 | One-cycle pulse when the line returns to idle |

## Verification
The bench builds the block with its default timing: a 32-tick header mark, an 8-tick gap, 16- and 8-tick spaces and an 8-tick mark. With these values, the longest frame (all ones, 616 ticks) finishes in a few thousand cycles even when ticks are sparse. Frames are run under three tick patterns: every cycle, every third cycle, and a pseudo-random pattern. This shows that run lengths are counted in ticks and not in clocks. One frame is all zeros and one is all ones, which gives the shortest and the longest frame. The header gap merges with the first data space, and the scoreboard expects that merged run. Another frame receives a second start strobe in the middle of its data bits.

// File: rtl/irtag_pkg.sv
package irtag_pkg;

    // Phase of the frame being generated
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_HDR_MARK = 3'd1,
        PH_HDR_GAP  = 3'd2,
        PH_SPACE    = 3'd3,
        PH_MARK     = 3'd4
    } phase_e;

    // Phases in which the line is at its active level
    function automatic logic phase_is_active(phase_e ph);
        return (ph == PH_HDR_MARK) || (ph == PH_MARK);
    endfunction

endpackage

// File: rtl/irtag_seg_timer.sv
// Tick-driven down counter measuring the length of one waveform segment.
module irtag_seg_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The segment ends on the tick that consumes its final sample
    assign expire = tick && (cnt_q == ONE);

endmodule

// File: rtl/irtag_shift_ser.sv
// Right-shifting frame register: bit 0 is the bit on the line now.
module irtag_shift_ser #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         cur_bit,
    output logic         nxt_bit
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = load_val;
        end else if (shift) begin
            sr_d = {1'b0, sr_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign cur_bit = sr_q[0];
    assign nxt_bit = sr_q[1];

endmodule

// File: rtl/irtag_frame_gen.sv
module irtag_frame_gen
    import irtag_pkg::*;
#(
    parameter int PAY_W        = 16,
    parameter int CHK_W        = 8,
    parameter int HDR_MARK_T   = 32,
    parameter int HDR_GAP_T    = 8,
    parameter int ONE_SPACE_T  = 16,
    parameter int ZERO_SPACE_T = 8,
    parameter int BIT_MARK_T   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    input  logic             start_i,
    input  logic [PAY_W-1:0] payload_i,
    input  logic [CHK_W-1:0] check_i,
    input  logic             invert_i,
    output logic             line_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int NBITS  = PAY_W + CHK_W;
    localparam int MAX_AB = (HDR_MARK_T > HDR_GAP_T) ? HDR_MARK_T : HDR_GAP_T;
    localparam int MAX_CD = (ONE_SPACE_T > ZERO_SPACE_T) ? ONE_SPACE_T : ZERO_SPACE_T;
    localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MAX_T  = (MAX_ABCD > BIT_MARK_T) ? MAX_ABCD : BIT_MARK_T;
    localparam int CW     = $clog2(MAX_T + 1);
    localparam int BCW    = $clog2(NBITS + 1);

    typedef struct packed {
        phase_e         phase;
        logic [BCW-1:0] bits_left;
        logic           done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expire;
    logic          ser_load;
    logic          ser_shift;
    logic          ser_cur;
    logic          ser_nxt;

    irtag_seg_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en_i),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    irtag_shift_ser #(.W(NBITS)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .load_val ({check_i, payload_i}),
        .shift    (ser_shift),
        .cur_bit  (ser_cur),
        .nxt_bit  (ser_nxt)
    );

    function automatic logic [CW-1:0] space_len(logic b);
        return b ? CW'(ONE_SPACE_T) : CW'(ZERO_SPACE_T);
    endfunction

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        ser_load   = 1'b0;
        ser_shift  = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.phase     = PH_HDR_MARK;
                    ctl_d.bits_left = BCW'(NBITS);
                    tmr_load        = 1'b1;
                    tmr_val         = CW'(HDR_MARK_T);
                    ser_load        = 1'b1;
                end
            end
            PH_HDR_MARK: begin
                if (tmr_expire) begin
                    ctl_d.phase = PH_HDR_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(HDR_GAP_T);
                end
            end
            PH_HDR_GAP: begin
                if (tmr_expire) begin
                    ctl_d.phase = PH_SPACE;
                    tmr_load    = 1'b1;
                    tmr_val     = space_len(ser_cur);
                end
            end
            PH_SPACE: begin
                if (tmr_expire) begin
                    ctl_d.phase = PH_MARK;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(BIT_MARK_T);
                end
            end
            PH_MARK: begin
                if (tmr_expire) begin
                    ser_shift       = 1'b1;
                    ctl_d.bits_left = ctl_q.bits_left - BCW'(1);
                    if (ctl_q.bits_left == BCW'(1)) begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.phase = PH_SPACE;
                        tmr_load    = 1'b1;
                        tmr_val     = space_len(ser_nxt);
                    end
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, bits_left: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign line_o = phase_is_active(ctl_q.phase) ^ invert_i;
    assign busy_o = (ctl_q.phase != PH_IDLE);
    assign done_o = ctl_q.done;

endmodule

// File: rtl/irtag_frame_gen_chk.sv
module irtag_frame_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en_i,
    input logic start_i,
    input logic invert_i,
    input logic line_o,
    input logic busy_o,
    input logic done_o
);
    // Idle line sits at the inactive level
    assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (line_o == invert_i));

    // Accepted start opens the header mark in the next cycle
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && $stable(invert_i)) |=> (busy_o && (line_o != invert_i)));

    // Without a tick the waveform holds
    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_en_i) |=> (busy_o && $stable(line_o ^ invert_i)));

    // Done is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Done coincides with the fall of busy
    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // A strobe during a frame cannot end it early without a tick
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tick_en_i) |=> busy_o);
endmodule

bind irtag_frame_gen irtag_frame_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .start_i   (start_i),
    .invert_i  (invert_i),
    .line_o    (line_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/irtag_frame_gen_tb.sv
module irtag_frame_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pay = '0;
    logic [7:0]  chk = '0;
    logic        invert = 1'b0;
    logic        line, busy, done;

    always #5 clk = ~clk;

    irtag_frame_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en),
        .start_i   (start),
        .payload_i (pay),
        .check_i   (chk),
        .invert_i  (invert),
        .line_o    (line),
        .busy_o    (busy),
        .done_o    (done)
    );

    int total = 0;
    int bad = 0;
    int tick_mode = 0;
    int frames_seen = 0;
    logic [15:0] lfsr = 16'hACE1;

    bit    exp_lvl[$];
    int    exp_len[$];
    string exp_tag[$];
    int    exp_total[$];

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_run(bit lvl, int len, string tag);
        exp_lvl.push_back(lvl);
        exp_len.push_back(len);
        exp_tag.push_back(tag);
    endtask

    // Driver: build the expected run list, then strobe start
    task automatic send_frame(logic [15:0] p, logic [7:0] c, string tag);
        logic [23:0] fr;
        int acc;
        int tot;
        int n0;
        fr  = {c, p};
        acc = 8;            // header gap merges with the first space (R3)
        tot = 40;
        push_run(1'b1, 32, {tag, " R3 header mark"});
        for (int i = 0; i < 24; i++) begin
            int sp;
            sp = fr[i] ? 16 : 8;
            tot += sp + 8;
            push_run(1'b0, acc + sp, fr[i] ? {tag, " R4 R5 one space"} : {tag, " R4 R6 zero space"});
            push_run(1'b1, 8, {tag, " R5 R6 bit mark"});
            acc = 0;
        end
        exp_total.push_back(tot);
        n0 = frames_seen;
        @(negedge clk);
        pay   = p;
        chk   = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (frames_seen == n0 + 1);
    endtask

    // Tick pattern generator
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            case (tick_mode)
                0: tick_en = 1'b1;
                1: begin
                    ph = (ph + 1) % 3;
                    tick_en = (ph == 0);
                end
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    tick_en = lfsr[0];
                end
            endcase
        end
    end

    task automatic compare_run(bit lvl, int len);
        if (exp_lvl.size() == 0) begin
            check(1'b0, "R9", "unexpected extra run", len, 0);
        end else begin
            bit    el;
            int    en;
            string et;
            el = exp_lvl.pop_front();
            en = exp_len.pop_front();
            et = exp_tag.pop_front();
            check(lvl == el, et, "run level", lvl, el);
            check(len == en, et, "run length", len, en);
        end
    endtask

    // Monitor: run-length scoreboard on ticked samples
    initial begin
        bit prev_busy;
        bit cur_lvl;
        int cur_len;
        int ticks;
        prev_busy = 1'b0;
        cur_lvl   = 1'b0;
        cur_len   = 0;
        ticks     = 0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                prev_busy = 1'b0;
            end else begin
                if (busy) begin
                    if (!prev_busy) begin
                        cur_len = 0;
                        ticks   = 0;
                    end
                    if (tick_en) begin
                        bit lvl;
                        lvl = line ^ invert;
                        ticks++;
                        if (cur_len == 0) begin
                            cur_lvl = lvl;
                            cur_len = 1;
                        end else if (lvl == cur_lvl) begin
                            cur_len++;
                        end else begin
                            compare_run(cur_lvl, cur_len);
                            cur_lvl = lvl;
                            cur_len = 1;
                        end
                    end
                end else if (prev_busy) begin
                    int et;
                    compare_run(cur_lvl, cur_len);
                    check(done == 1'b1, "R9", "done at end", done, 1);
                    check(line == invert, "R9", "idle line at end", line, invert);
                    et = (exp_total.size() != 0) ? exp_total.pop_front() : -1;
                    check(ticks == et, "R9", "frame tick count", ticks, et);
                    check(exp_lvl.size() == 0, "R4", "runs left over", exp_lvl.size(), 0);
                    exp_lvl.delete();
                    exp_len.delete();
                    exp_tag.delete();
                    frames_seen++;
                end
                prev_busy = busy;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(line == 1'b0, "R1", "line in reset", line, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(line == 1'b0, "R1", "line after reset", line, 0);

        // R2 R4: mixed pattern, tick every cycle
        tick_mode = 0;
        send_frame(16'hA5C3, 8'h5E, "R2");

        // R7 R6: all zeros, sparse regular ticks (shortest frame)
        tick_mode = 1;
        send_frame(16'h0000, 8'h00, "R7");

        // R10: inverted polarity, check idle level first
        @(negedge clk);
        invert = 1'b1;
        #2;
        check(line == 1'b1, "R10", "idle line inverted", line, 1);
        // R7 R5: all ones, pseudo-random ticks (longest frame)
        tick_mode = 2;
        send_frame(16'hFFFF, 8'hFF, "R10");
        @(negedge clk);
        invert = 1'b0;

        // R8: strobe with other data in the middle of a frame
        tick_mode = 0;
        fork
            send_frame(16'h1234, 8'h80, "R8");
            begin
                repeat (120) @(negedge clk);
                pay   = 16'hFFFF;
                chk   = 8'h00;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join

        // back-to-back frame right after done
        send_frame(16'h8001, 8'h7E, "R4");

        repeat (4) @(negedge clk);
        #2;
        check(busy == 1'b0, "R8", "no extra frame after ignored strobe", busy, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule